// File: doc/BRIEF.md
# Slot Hotplug Notifier with General-Purpose Event Registers

This block tells host software that an expansion slot has gained or lost a device. Each hotplug event records the affected slot in one of two slot bitmaps, one for insertions and one for removals. It also latches a pending flag in a 16-bit event status register. If the matching bit of a 16-bit event enable register is set, the block raises a one-cycle interrupt pulse.

Software reaches the block through a single-cycle register port. Reads are combinational and have no side effects. The status register is read a byte at a time and cleared by writing ones to the bits to be cleared. The enable register is rewritten a byte at a time. The two bitmaps are full-width words that can be read and overwritten. Writing a slot mask to the eject port produces one strobe, and the strobe carries the index of the lowest set bit of the mask. The device removal itself happens outside the block.

Top module: `hp_event_unit`

Register offsets (byte addresses on `addr`):

| Offset | Register |
|--------|----------|
| 0x00 | event status, bits 7:0 |
| 0x01 | event status, bits 15:8 |
| 0x02 | event enable, bits 7:0 |
| 0x03 | event enable, bits 15:8 |
| 0x10 | inserted-slot bitmap |
| 0x14 | removed-slot bitmap |
| 0x18 | eject port |

All other offsets are unassigned.

## Requirements
- R1: While `rst` is high at a clock edge, both event registers and both bitmaps return to zero, and `irq_pulse` and `eject_valid` are low in the following cycle.
- R2: A write to offset 0x00 or 0x01 clears, in that byte of the status register only, each bit whose `wr_data[7:0]` bit is one. The other status byte and all zero-written bits are unchanged.
- R3: A write to offset 0x02 or 0x03 replaces only that byte of the enable register with `wr_data[7:0]`.
- R4: The inserted bitmap at 0x10 and the removed bitmap at 0x14 read back, zero-extended, the full value last written to them.
- R5: When `hp_valid` is high at an edge, both bitmaps become zero except bit `hp_slot`. That bit is set in the inserted bitmap if `hp_insert` is 1 and in the removed bitmap if it is 0. Status bit 1 becomes one. All of this is visible from the next cycle.
- R6: `irq_pulse` is high for exactly the cycle after an edge where `hp_valid` was high and enable bit 1 held one before that edge. In every other cycle it is low.
- R7: A write to 0x18 with a nonzero value sets `eject_valid` for the next cycle, with `eject_slot` equal to the index of the lowest set bit of `wr_data`. A read of 0x18 returns zero.
- R8: A write of all zeros to 0x18 produces no `eject_valid`.
- R9: When a hotplug event and a host write to a bitmap or to status byte 0x00 fall on the same edge, the hotplug update wins. The bitmaps take the event's value, and status bit 1 ends up set.
- R10: Reads of unassigned offsets return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hp_valid | input | 1 | Hotplug event strobe |
| hp_slot | input | SLOT_W | Slot number of the event |
| hp_insert | input | 1 | 1 = insertion, 0 = removal |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Register byte offset |
| wr_data | input | 32 | Write data (byte registers use bits 7:0) |
| rd_data | output | 32 | Combinational read data for `addr` |
| irq_pulse | output | 1 | One-cycle event interrupt |
| eject_valid | output | 1 | Eject strobe |
| eject_slot | output | SLOT_W | Slot selected by the eject write |

## Verification
A hotplug event can arrive on the same edge as a host write to the register it updates. The two cases that matter are a bitmap overwrite and a write-one-to-clear of status bit 1. The bench provokes both with directed stimulus. It drives `hp_valid` together with `wr_en` at 0x10, at 0x14 and at 0x00 with bit 1 set. It then reads back and expects the event's one-hot bitmap and a set status bit 1. Random cycles also mix events with writes to every offset, and a bench model that applies the host write first and the event second judges each read.

// File: rtl/hp_pkg.sv
package hp_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] OFF_STS_LO = 6'h00;
    localparam logic [ADDR_W-1:0] OFF_STS_HI = 6'h01;
    localparam logic [ADDR_W-1:0] OFF_EN_LO  = 6'h02;
    localparam logic [ADDR_W-1:0] OFF_EN_HI  = 6'h03;
    localparam logic [ADDR_W-1:0] OFF_INS    = 6'h10;
    localparam logic [ADDR_W-1:0] OFF_REM    = 6'h14;
    localparam logic [ADDR_W-1:0] OFF_EJECT  = 6'h18;

    // Status/enable bit driven by slot hotplug events
    localparam int HP_EVENT_BIT = 1;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_STS, SEL_EN, SEL_INS, SEL_REM, SEL_EJECT
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e sel;
        logic     hi;
    } reg_dec_t;

    function automatic reg_dec_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_dec_t d;
        d.hi = 1'b0;
        case (a)
            OFF_STS_LO: d.sel = SEL_STS;
            OFF_STS_HI: begin d.sel = SEL_STS; d.hi = 1'b1; end
            OFF_EN_LO:  d.sel = SEL_EN;
            OFF_EN_HI:  begin d.sel = SEL_EN;  d.hi = 1'b1; end
            OFF_INS:    d.sel = SEL_INS;
            OFF_REM:    d.sel = SEL_REM;
            OFF_EJECT:  d.sel = SEL_EJECT;
            default:    d.sel = SEL_NONE;
        endcase
        return d;
    endfunction

    // Place a byte into one half of a 16-bit register image
    function automatic logic [15:0] byte_lane(input logic [7:0] b, input logic hi);
        return hi ? {b, 8'h00} : {8'h00, b};
    endfunction
endpackage

// File: rtl/hp_gpe_regs.sv
module hp_gpe_regs
    import hp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  reg_dec_t    dec,
    input  logic [7:0]  wr_byte,
    input  logic        event_set,
    output logic [15:0] status,
    output logic [15:0] enable
);
    logic [15:0] clr_mask;
    logic [15:0] lane_mask;
    logic [15:0] status_next;
    logic [15:0] enable_next;

    always_comb begin
        lane_mask = byte_lane(8'hFF, dec.hi);
        clr_mask  = (wr_en && dec.sel == SEL_STS) ? byte_lane(wr_byte, dec.hi) : 16'h0000;
        // host clear first, event set last: the event wins on a collision
        status_next = status & ~clr_mask;
        if (event_set) status_next[HP_EVENT_BIT] = 1'b1;
        enable_next = enable;
        if (wr_en && dec.sel == SEL_EN)
            enable_next = (enable & ~lane_mask) | byte_lane(wr_byte, dec.hi);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            enable <= '0;
        end else begin
            status <= status_next;
            enable <= enable_next;
        end
    end
endmodule

// File: rtl/hp_slot_maps.sv
module hp_slot_maps
    import hp_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  reg_sel_e             sel,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 ev_valid,
    input  logic [SLOT_W-1:0]    ev_slot,
    input  logic                 ev_insert,
    output logic [NUM_SLOTS-1:0] ins_map,
    output logic [NUM_SLOTS-1:0] rem_map
);
    logic [NUM_SLOTS-1:0] onehot;
    logic [NUM_SLOTS-1:0] ins_next;
    logic [NUM_SLOTS-1:0] rem_next;

    always_comb begin
        onehot = '0;
        onehot[ev_slot] = 1'b1;
        ins_next = ins_map;
        rem_next = rem_map;
        if (wr_en && sel == SEL_INS) ins_next = wr_data[NUM_SLOTS-1:0];
        if (wr_en && sel == SEL_REM) rem_next = wr_data[NUM_SLOTS-1:0];
        if (ev_valid) begin
            ins_next = ev_insert ? onehot : '0;
            rem_next = ev_insert ? '0 : onehot;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ins_map <= '0;
            rem_map <= '0;
        end else begin
            ins_map <= ins_next;
            rem_map <= rem_next;
        end
    end
endmodule

// File: rtl/hp_eject_dec.sv
module hp_eject_dec
    import hp_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic [DATA_W-1:0] wr_data,
    output logic              eject_valid,
    output logic [SLOT_W-1:0] eject_slot
);
    logic [NUM_SLOTS-1:0] mask;
    logic [SLOT_W-1:0]    low_idx;
    logic                 any_set;

    always_comb begin
        mask    = wr_data[NUM_SLOTS-1:0];
        any_set = |mask;
        low_idx = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (mask[i]) low_idx = SLOT_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            eject_valid <= 1'b0;
            eject_slot  <= '0;
        end else begin
            eject_valid <= hit && any_set;
            if (hit && any_set) eject_slot <= low_idx;
        end
    end
endmodule

// File: rtl/hp_event_unit.sv
module hp_event_unit
    import hp_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hp_valid,
    input  logic [SLOT_W-1:0] hp_slot,
    input  logic              hp_insert,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_pulse,
    output logic              eject_valid,
    output logic [SLOT_W-1:0] eject_slot
);
    reg_dec_t             dec;
    logic [15:0]          gpe_status;
    logic [15:0]          gpe_enable;
    logic [NUM_SLOTS-1:0] ins_map;
    logic [NUM_SLOTS-1:0] rem_map;

    assign dec = decode_addr(addr);

    hp_gpe_regs u_gpe (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .dec       (dec),
        .wr_byte   (wr_data[7:0]),
        .event_set (hp_valid),
        .status    (gpe_status),
        .enable    (gpe_enable)
    );

    hp_slot_maps #(.NUM_SLOTS(NUM_SLOTS)) u_maps (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .sel       (dec.sel),
        .wr_data   (wr_data),
        .ev_valid  (hp_valid),
        .ev_slot   (hp_slot),
        .ev_insert (hp_insert),
        .ins_map   (ins_map),
        .rem_map   (rem_map)
    );

    hp_eject_dec #(.NUM_SLOTS(NUM_SLOTS)) u_eject (
        .clk         (clk),
        .rst         (rst),
        .hit         (wr_en && dec.sel == SEL_EJECT),
        .wr_data     (wr_data),
        .eject_valid (eject_valid),
        .eject_slot  (eject_slot)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_pulse <= 1'b0;
        else     irq_pulse <= hp_valid && gpe_enable[HP_EVENT_BIT];
    end

    always_comb begin
        case (dec.sel)
            SEL_STS: rd_data = DATA_W'(dec.hi ? gpe_status[15:8] : gpe_status[7:0]);
            SEL_EN:  rd_data = DATA_W'(dec.hi ? gpe_enable[15:8] : gpe_enable[7:0]);
            SEL_INS: rd_data = DATA_W'(ins_map);
            SEL_REM: rd_data = DATA_W'(rem_map);
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/hp_event_unit_chk.sv
module hp_event_unit_chk
    import hp_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 hp_valid,
    input logic                 wr_en,
    input logic [ADDR_W-1:0]    addr,
    input logic [DATA_W-1:0]    wr_data,
    input logic                 irq_pulse,
    input logic                 eject_valid,
    input logic [SLOT_W-1:0]    eject_slot,
    input logic [15:0]          gpe_status,
    input logic [15:0]          gpe_enable,
    input logic [NUM_SLOTS-1:0] ins_map,
    input logic [NUM_SLOTS-1:0] rem_map
);
    AST_EVENT_SETS_STATUS: assert property (@(posedge clk) disable iff (rst)
        hp_valid |=> gpe_status[HP_EVENT_BIT]); // R5

    AST_EVENT_SINGLE_SLOT: assert property (@(posedge clk) disable iff (rst)
        hp_valid |=> ($countones({ins_map, rem_map}) == 1)); // R9

    AST_IRQ_FROM_EVENT: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> ($past(hp_valid) && $past(gpe_enable[HP_EVENT_BIT]))); // R6

    AST_EJECT_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        eject_valid |-> $past(wr_en && addr == OFF_EJECT && wr_data != '0)); // R8

    AST_EJECT_BIT_SET: assert property (@(posedge clk) disable iff (rst)
        eject_valid |-> ((($past(wr_data) >> eject_slot) & 32'd1) == 32'd1)); // R7
endmodule

bind hp_event_unit hp_event_unit_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .hp_valid    (hp_valid),
    .wr_en       (wr_en),
    .addr        (addr),
    .wr_data     (wr_data),
    .irq_pulse   (irq_pulse),
    .eject_valid (eject_valid),
    .eject_slot  (eject_slot),
    .gpe_status  (gpe_status),
    .gpe_enable  (gpe_enable),
    .ins_map     (ins_map),
    .rem_map     (rem_map)
);

// File: tb/hp_event_unit_test.sv
module hp_event_unit_test;
    localparam int SW = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hp_valid = 1'b0;
    logic [SW-1:0] hp_slot = '0;
    logic        hp_insert = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq_pulse;
    logic        eject_valid;
    logic [SW-1:0] eject_slot;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [15:0] m_sts = '0, m_en = '0;
    logic [31:0] m_ins = '0, m_rem = '0;

    always #10 clk = ~clk;

    hp_event_unit uut (
        .clk(clk), .rst(rst), .hp_valid(hp_valid), .hp_slot(hp_slot),
        .hp_insert(hp_insert), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .irq_pulse(irq_pulse), .eject_valid(eject_valid),
        .eject_slot(eject_slot)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [5:0] a);
        case (a)
            6'h00: return {24'h0, m_sts[7:0]};
            6'h01: return {24'h0, m_sts[15:8]};
            6'h02: return {24'h0, m_en[7:0]};
            6'h03: return {24'h0, m_en[15:8]};
            6'h10: return m_ins;
            6'h14: return m_rem;
            default: return 32'h0;
        endcase
    endfunction

    function automatic int lowest_bit(input logic [31:0] d);
        for (int i = 0; i < 32; i++) if (d[i]) return i;
        return 0;
    endfunction

    // One cycle: drive at negedge, check read now, check registered outputs at next negedge
    task automatic cyc(input bit ev, input logic [SW-1:0] sl, input bit ins,
                       input bit we, input logic [5:0] a, input logic [31:0] d,
                       input string rtag);
        bit exp_irq, exp_ej;
        int exp_slot;
        hp_valid = ev; hp_slot = sl; hp_insert = ins;
        wr_en = we; addr = a; wr_data = d;
        #1;
        chk({rtag, " read"}, rd_data, exp_read(a));
        exp_irq  = ev && m_en[1];
        exp_ej   = we && a == 6'h18 && d != 0;
        exp_slot = lowest_bit(d);
        if (we) begin
            case (a)
                6'h00: m_sts = m_sts & ~{8'h0, d[7:0]};
                6'h01: m_sts = m_sts & ~{d[7:0], 8'h0};
                6'h02: m_en  = {m_en[15:8], d[7:0]};
                6'h03: m_en  = {d[7:0], m_en[7:0]};
                6'h10: m_ins = d;
                6'h14: m_rem = d;
                default: ;
            endcase
        end
        if (ev) begin
            m_ins = 0; m_rem = 0;
            if (ins) m_ins[sl] = 1'b1; else m_rem[sl] = 1'b1;
            m_sts[1] = 1'b1;
        end
        @(negedge clk);
        hp_valid = 0; wr_en = 0;
        chk("R6 irq_pulse", {31'h0, irq_pulse}, {31'h0, exp_irq});
        chk("R7/R8 eject_valid", {31'h0, eject_valid}, {31'h0, exp_ej});
        if (exp_ej) chk("R7 eject_slot", {27'h0, eject_slot}, exp_slot[31:0]);
    endtask

    task automatic rd_all(input string rtag);
        logic [5:0] offs [8] = '{6'h00, 6'h01, 6'h02, 6'h03, 6'h10, 6'h14, 6'h18, 6'h3C};
        foreach (offs[i]) begin
            addr = offs[i];
            #1;
            chk(rtag, rd_data, exp_read(offs[i]));
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        logic [5:0] pool [9] = '{6'h00, 6'h01, 6'h02, 6'h03, 6'h10, 6'h14, 6'h18, 6'h04, 6'h2A};
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        rd_all("R1 reset");
        chk("R1 irq low", {31'h0, irq_pulse}, 32'h0);
        chk("R1 eject low", {31'h0, eject_valid}, 32'h0);

        // R3: enable byte writes
        cyc(0, 0, 0, 1, 6'h02, 32'hFFFF_FF5A, "R3");
        cyc(0, 0, 0, 1, 6'h03, 32'h0000_00C3, "R3");
        rd_all("R3 enable bytes");
        // R5/R6: insertion event with enable bit 1 set
        cyc(1, 5'd7, 1, 0, 6'h00, 0, "R5");
        rd_all("R5 insert event");
        // R6: disable bit 1, removal event must not interrupt
        cyc(0, 0, 0, 1, 6'h02, 32'h0000_0058, "R3");
        cyc(1, 5'd31, 0, 0, 6'h10, 0, "R6");
        rd_all("R5 remove event");
        // R2: W1C per byte
        cyc(0, 0, 0, 1, 6'h01, 32'h0000_00FF, "R2");
        rd_all("R2 hi byte clear");
        cyc(0, 0, 0, 1, 6'h00, 32'h0000_0002, "R2");
        rd_all("R2 lo byte clear");
        // R4: bitmap writes
        cyc(0, 0, 0, 1, 6'h10, 32'hDEAD_BEEF, "R4");
        cyc(0, 0, 0, 1, 6'h14, 32'h1234_5678, "R4");
        rd_all("R4 bitmaps");
        // R10: unassigned writes ignored
        cyc(0, 0, 0, 1, 6'h04, 32'hFFFF_FFFF, "R10");
        cyc(0, 0, 0, 1, 6'h3F, 32'hFFFF_FFFF, "R10");
        rd_all("R10 unassigned");
        // R7/R8: eject
        cyc(0, 0, 0, 1, 6'h18, 32'h8000_0000, "R7");
        cyc(0, 0, 0, 1, 6'h18, 32'h0000_000C, "R7");
        cyc(0, 0, 0, 1, 6'h18, 32'h0000_0000, "R8");
        rd_all("R7 eject read zero");
        // R9: collisions
        cyc(0, 0, 0, 1, 6'h02, 32'h0000_0002, "R3");
        cyc(1, 5'd3, 1, 1, 6'h10, 32'hFFFF_FFFF, "R9");
        cyc(1, 5'd9, 0, 1, 6'h14, 32'hFFFF_FFFF, "R9");
        cyc(1, 5'd0, 1, 1, 6'h00, 32'h0000_00FF, "R9");
        rd_all("R9 event wins");
        // Random mix
        for (int n = 0; n < 400; n++) begin
            bit ev = ($urandom % 3) == 0;
            bit we = ($urandom % 2) == 0;
            logic [5:0] a = pool[$urandom % 9];
            logic [31:0] d = ($urandom % 4 == 0) ? 32'h0 : $urandom;
            cyc(ev, SW'($urandom % 32), 1'($urandom % 2), we, a, d, "R9 random");
        end
        rd_all("R4 final");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule